// File: doc/BRIEF.md
# Shared-Waveform LED Dimming Controller

This block drives a row of LED output pins from a single pulse-width generator. Every pin that is switched into dimming use shows either the common dimmed waveform or a fixed level. Which one it shows depends on the state of the touch button paired with that pin and on one dimming behaviour chosen for the whole row. A pin that is not in dimming use simply repeats its bit of a plain output word.

The generator counts a 16-cycle period and holds its output high for as many cycles as the 4-bit duty code says. Button changes do not reach the pins directly. A small sequencer with the states RUN, WAIT and APPLY commits them. RUN goes to APPLY when the delay is zero and to WAIT otherwise, as soon as the sampled buttons differ from the committed ones. WAIT goes to APPLY after the programmed number of period wraps. APPLY always returns to RUN. APPLY is the only state in which the committed buttons change, and in that cycle it reports the press and release edges that the latching behaviours use.

Top module: `dim_pwm_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, every pin is low. The period counter starts at zero.
- R2: When a pin's enable bit is 0, the pin equals that pin's bit of `out_reg_i`, registered once.
- R3: The waveform has a period of 16 clock cycles. It is high for n cycles per period for duty code n (1 to 15) and never high for code 0.
- R4: Behaviour code 0 (follow): a pressed button gives static 1 and a released button gives the waveform.
- R5: Behaviour code 1 (flash): a pressed button gives the waveform and a released button gives static 0.
- R6: Behaviour code 2 (hold): a pin is static 0 until a release edge of its button. From then on it shows the waveform.
- R7: Behaviour code 3 (toggle): every press or release edge flips the pin between static 0 (the initial choice) and the waveform.
- R8: Any change of the behaviour code clears every per-pin latch used by codes 2 and 3.
- R9: With delay d > 0, a button change is committed only on the d-th period wrap after the sequencer sees it. With d = 0 it is committed in the following cycle. The committed buttons change nowhere else.
- R10: All pins that show the waveform show it in the same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| btn_i | input | NPIN | Button pressed (1) per pin |
| en_i | input | NPIN | Pin uses dimming logic (1) or plain output (0) |
| out_reg_i | input | NPIN | Plain output level for non-dimming pins |
| duty_i | input | 4 | Duty code, 0 to 15 |
| mode_i | input | 2 | Behaviour code: 0 follow, 1 flash, 2 hold, 3 toggle |
| dly_i | input | DLY_W | Delay in waveform periods |
| pin_o | output | NPIN | Pin levels |

## Verification
The bench goes after the end points of the duty code. A comparator off by one would show 16 high cycles at code 15, or a sliver of high time at code 0. It builds edge histories for the hold and toggle behaviours. Wrong edge polarity, or an edge counted twice, leaves those pins in the wrong state. It also switches behaviours with a button held down. If the latches survive the switch, the pin shows the waveform where it should be dark. Finally it checks that a nonzero delay keeps the old choice for more than a full period, while a zero delay settles within a few cycles.

// File: rtl/dim_pwm_pkg.sv
package dim_pwm_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_APPLY = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        BEH_FOLLOW = 2'd0,
        BEH_FLASH  = 2'd1,
        BEH_HOLD   = 2'd2,
        BEH_TOGGLE = 2'd3
    } beh_t;

    localparam int unsigned DUTY_W = 4;
endpackage

// File: rtl/dim_pwm_gen.sv
module dim_pwm_gen
    import dim_pwm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [DUTY_W-1:0] cnt_o,
    output logic              wave_o,
    output logic              wrap_o
);
    logic [DUTY_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wave_o = (cnt_q < duty_i);
    assign wrap_o = (cnt_q == {DUTY_W{1'b1}});
endmodule

// File: rtl/dim_btn_seq.sv
module dim_btn_seq
    import dim_pwm_pkg::*;
#(
    parameter int unsigned NPIN  = 10,
    parameter int unsigned DLY_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPIN-1:0]  btn_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             wrap_i,
    output logic [NPIN-1:0]  eff_o,
    output logic [NPIN-1:0]  rise_o,
    output logic [NPIN-1:0]  fall_o,
    output seq_state_t       state_o
);
    seq_state_t       state_q, state_d;
    logic [NPIN-1:0]  btn_q, eff_q;
    logic [DLY_W-1:0] dcnt_q, dcnt_d;

    always_comb begin
        state_d = state_q;
        dcnt_d  = dcnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (btn_q != eff_q) begin
                    dcnt_d  = dly_i;
                    state_d = (dly_i == '0) ? ST_APPLY : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (wrap_i) begin
                    if (dcnt_q <= 1) state_d = ST_APPLY;
                    else             dcnt_d  = dcnt_q - 1'b1;
                end
            end
            ST_APPLY: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            dcnt_q  <= '0;
            btn_q   <= '0;
            eff_q   <= '0;
        end else begin
            state_q <= state_d;
            dcnt_q  <= dcnt_d;
            btn_q   <= btn_i;
            if (state_q == ST_APPLY) eff_q <= btn_q;
        end
    end

    always_comb begin
        eff_o   = eff_q;
        state_o = state_q;
        rise_o  = '0;
        fall_o  = '0;
        if (state_q == ST_APPLY) begin
            rise_o = btn_q & ~eff_q;
            fall_o = ~btn_q & eff_q;
        end
    end
endmodule

// File: rtl/dim_pin_mux.sv
module dim_pin_mux
    import dim_pwm_pkg::*;
#(
    parameter int unsigned NPIN = 10
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [1:0]      mode_i,
    input  logic            wave_i,
    input  logic [NPIN-1:0] eff_i,
    input  logic [NPIN-1:0] rise_i,
    input  logic [NPIN-1:0] fall_i,
    input  logic [NPIN-1:0] en_i,
    input  logic [NPIN-1:0] out_reg_i,
    output beh_t            mode_o,
    output logic [NPIN-1:0] pin_o
);
    beh_t            mode_q;
    logic [NPIN-1:0] latch_q, pin_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q  <= BEH_FOLLOW;
            latch_q <= '0;
        end else if (beh_t'(mode_i) != mode_q) begin
            mode_q  <= beh_t'(mode_i);
            latch_q <= '0;
        end else begin
            unique case (mode_q)
                BEH_HOLD:   latch_q <= latch_q | fall_i;
                BEH_TOGGLE: latch_q <= latch_q ^ (rise_i | fall_i);
                default:    latch_q <= latch_q;
            endcase
        end
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic sel;
        always_comb begin
            unique case (mode_q)
                BEH_FOLLOW: sel = eff_i[g] ? 1'b1 : wave_i;
                BEH_FLASH:  sel = eff_i[g] ? wave_i : 1'b0;
                default:    sel = latch_q[g] ? wave_i : 1'b0;
            endcase
        end
        always_ff @(posedge clk_i) begin
            if (!rst_ni) pin_q[g] <= 1'b0;
            else         pin_q[g] <= en_i[g] ? sel : out_reg_i[g];
        end
    end

    assign pin_o  = pin_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/dim_pwm_ctrl.sv
module dim_pwm_ctrl
    import dim_pwm_pkg::*;
#(
    parameter int unsigned NPIN  = 10,
    parameter int unsigned DLY_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPIN-1:0]  btn_i,
    input  logic [NPIN-1:0]  en_i,
    input  logic [NPIN-1:0]  out_reg_i,
    input  logic [3:0]       duty_i,
    input  logic [1:0]       mode_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic [NPIN-1:0]  pin_o
);
    logic [DUTY_W-1:0] cnt;
    logic              wave, wrap;
    logic [NPIN-1:0]   eff_btn, rise, fall;
    seq_state_t        seq_state;
    beh_t              mode_q;

    dim_pwm_gen u_gen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .duty_i (duty_i),
        .cnt_o  (cnt),
        .wave_o (wave),
        .wrap_o (wrap)
    );

    dim_btn_seq #(.NPIN(NPIN), .DLY_W(DLY_W)) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .btn_i   (btn_i),
        .dly_i   (dly_i),
        .wrap_i  (wrap),
        .eff_o   (eff_btn),
        .rise_o  (rise),
        .fall_o  (fall),
        .state_o (seq_state)
    );

    dim_pin_mux #(.NPIN(NPIN)) u_mux (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode_i),
        .wave_i    (wave),
        .eff_i     (eff_btn),
        .rise_i    (rise),
        .fall_i    (fall),
        .en_i      (en_i),
        .out_reg_i (out_reg_i),
        .mode_o    (mode_q),
        .pin_o     (pin_o)
    );
endmodule

// File: rtl/dim_pwm_chk.sv
module dim_pwm_chk
    import dim_pwm_pkg::*;
#(
    parameter int unsigned NPIN = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NPIN-1:0]   en_i,
    input logic [NPIN-1:0]   out_reg_i,
    input logic [3:0]        duty_i,
    input logic [NPIN-1:0]   pin_o,
    input logic [DUTY_W-1:0] cnt,
    input seq_state_t        seq_state,
    input logic [NPIN-1:0]   eff_btn,
    input beh_t              mode_q
);
    AST_DISABLED_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (((pin_o ^ $past(out_reg_i)) & ~$past(en_i)) == '0)); // R2
    AST_PERIOD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cnt == $past(cnt) + 1'b1)); // R3
    AST_ZERO_DUTY_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (duty_i == 4'd0 && mode_q == BEH_FLASH) |=> ((pin_o & $past(en_i)) == '0)); // R3
    AST_FLASH_IDLE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == BEH_FLASH && eff_btn == '0) |=> ((pin_o & $past(en_i)) == '0)); // R5
    AST_APPLY_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_state == ST_APPLY) |=> (seq_state == ST_RUN)); // R9
    AST_COMMIT_ONLY_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_state != ST_APPLY) |=> $stable(eff_btn)); // R9
endmodule

bind dim_pwm_ctrl dim_pwm_chk #(.NPIN(NPIN)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .out_reg_i (out_reg_i),
    .duty_i    (duty_i),
    .pin_o     (pin_o),
    .cnt       (cnt),
    .seq_state (seq_state),
    .eff_btn   (eff_btn),
    .mode_q    (mode_q)
);

// File: tb/test_dim_pwm_ctrl.sv
module test_dim_pwm_ctrl;
    localparam int NPIN = 10;
    localparam int NVEC = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] btn = '0, en = '0, outr = '0;
    logic [3:0]      duty = '0;
    logic [1:0]      mode = '0;
    logic [3:0]      dly = '0;
    logic [NPIN-1:0] pin;

    int checks = 0, failures = 0;
    bit done = 0;
    int hc [NPIN];
    bit phase_ok;

    always #2 clk = ~clk;

    dim_pwm_ctrl #(.NPIN(NPIN), .DLY_W(4)) i_dim_pwm_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .en_i(en), .out_reg_i(outr),
        .duty_i(duty), .mode_i(mode), .dly_i(dly), .pin_o(pin)
    );

    // fields: mode, duty, en, out, b0, b1, b2
    localparam logic [55:0] VEC [NVEC] = '{
        {2'd0, 4'd5,  10'h3FF, 10'h000, 10'h000, 10'h000, 10'h0F0},
        {2'd0, 4'd15, 10'h0FF, 10'h300, 10'h000, 10'h3FF, 10'h155},
        {2'd1, 4'd8,  10'h3FF, 10'h000, 10'h000, 10'h000, 10'h0AA},
        {2'd1, 4'd0,  10'h3FF, 10'h000, 10'h3FF, 10'h000, 10'h3FF},
        {2'd2, 4'd3,  10'h3FF, 10'h000, 10'h000, 10'h00F, 10'h003},
        {2'd2, 4'd12, 10'h1FF, 10'h200, 10'h3C0, 10'h300, 10'h3F0},
        {2'd3, 4'd7,  10'h3FF, 10'h000, 10'h000, 10'h00F, 10'h033},
        {2'd3, 4'd1,  10'h2AA, 10'h155, 10'h0FF, 10'h0FF, 10'h00F}
    };

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // count high cycles per pin over one period; pins expected to show
    // the waveform (mask) must agree with each other in every sample
    task automatic measure(input logic [NPIN-1:0] pwm_mask);
        phase_ok = 1;
        for (int i = 0; i < NPIN; i++) hc[i] = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            for (int i = 0; i < NPIN; i++) hc[i] += int'(pin[i]);
            if ((pin & pwm_mask) != '0 && (pin & pwm_mask) != pwm_mask) phase_ok = 0;
        end
    endtask

    task automatic check_pin(input string req, input int p, input int exp);
        checks++;
        if (hc[p] != exp) begin
            failures++;
            $display("FAIL %s pin%0d high_cycles actual=%0d expected=%0d", req, p, hc[p], exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(3);
        checks++;
        if (pin !== '0) begin failures++; $display("FAIL R1 in reset actual=%h expected=0", pin); end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pin !== '0) begin failures++; $display("FAIL R1 after reset actual=%h expected=0", pin); end

        // table walk: R2..R7, R10
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] m; logic [3:0] d; logic [NPIN-1:0] e, o, b0, b1, b2, lat, wmask;
            string req;
            {m, d, e, o, b0, b1, b2} = VEC[v];
            dly = 0; duty = d; en = e; outr = o;
            mode = m ^ 2'd1; btn = b0; cyc(40);
            mode = m; cyc(10);
            btn = b1; cyc(40);
            btn = b2; cyc(40);
            lat = (m == 2'd2) ? ((b0 & ~b1) | (b1 & ~b2)) : (b0 ^ b2);
            wmask = '0;
            for (int i = 0; i < NPIN; i++) begin
                if (e[i]) begin
                    case (m)
                        2'd0: wmask[i] = ~b2[i];
                        2'd1: wmask[i] = b2[i];
                        default: wmask[i] = lat[i];
                    endcase
                end
            end
            measure(d != 0 ? wmask : '0);
            case (m)
                2'd0: req = "R4";
                2'd1: req = "R5";
                2'd2: req = "R6";
                default: req = "R7";
            endcase
            for (int i = 0; i < NPIN; i++) begin
                int exp;
                if (!e[i])          begin exp = o[i] ? 16 : 0; check_pin("R2", i, exp); end
                else if (wmask[i])  begin exp = d; check_pin(d inside {0, 15} ? "R3" : req, i, exp); end
                else begin
                    exp = (m == 2'd0 && b2[i]) ? 16 : 0;
                    check_pin(req, i, exp);
                end
            end
            checks++;
            if (!phase_ok) begin
                failures++;
                $display("FAIL R10 vector %0d actual=phase_mismatch expected=aligned", v);
            end
        end

        // R8: latch cleared by a behaviour change while button held
        en = 10'h001; outr = '0; duty = 4'd6; dly = 0;
        mode = 2'd0; btn = '0; cyc(40);
        mode = 2'd3; cyc(10);
        btn = 10'h001; cyc(40);
        measure('0); check_pin("R7", 0, 6);
        mode = 2'd2; cyc(40);
        measure('0); check_pin("R8", 0, 0);
        btn = '0; cyc(40);
        measure('0); check_pin("R6", 0, 6);

        // R9: delay in waveform periods
        mode = 2'd0; duty = 4'd4; btn = '0; cyc(40);
        dly = 4'd2;
        btn = 10'h001; cyc(2);
        measure('0); check_pin("R9", 0, 4);
        cyc(60);
        measure('0); check_pin("R9", 0, 16);
        dly = 4'd0;
        btn = '0; cyc(5);
        measure('0); check_pin("R9", 0, 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule